// File: doc/BRIEF.md
# Stretched System Reset Generator

This block turns three reset causes into one clean system reset. The causes are the power-on condition of the registers, a supply-good flag that drops while the rail sags, and a raw active-low push-button pin. Reset rises on the first clock edge after any cause is seen. It is released only after a programmable number of quiet cycles has passed since the last cause went away. A cause that returns inside that window starts the window again from full length.

The push-button pin passes through a two-stage synchronizer and a stability filter. A new pin level counts only after it has held for a programmable number of cycles, so contact bounce and short glitches have no effect. Two reset polarities are provided, both from registers, and each is always the inverse of the other. A watchdog can only cause a reset if its timeout is wired to the push-button pin outside this block. No other input exists for it.

Top module: `rst_stretch_gen`

## Requirements
- R1: Out of the power-on initial state with `supply_ok`=1 and `mr_raw_n`=1, `rst`=1 after each of the first HOLD_CYC clock edges, and `rst`=0 after edge HOLD_CYC+1.
- R2: When `supply_ok`=0 is sampled at a clock edge, `rst`=1 after that edge.
- R3: When `mr_raw_n` is driven to 0 and stays 0, `rst`=1 after the (DEB_CYC+3)th edge that follows the change. Two edges go to synchronizing and DEB_CYC edges go to filtering.
- R4: A low pulse on `mr_raw_n` that is sampled low for at most DEB_CYC-1 consecutive edges does not change `rst`.
- R5: Reset falls exactly HOLD_CYC edges after the last edge at which a cause was active. For the push-button this is DEB_CYC+2+HOLD_CYC edges after `mr_raw_n` returns to 1.
- R6: A cause seen during the hold window reloads the full HOLD_CYC count.
- R7: `rst_n` equals the inverse of `rst` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| supply_ok | input | 1 | 1 while the supply is above its trip level |
| mr_raw_n | input | 1 | Raw manual reset pin, active low, may bounce |
| rst_n | output | 1 | System reset, active low |
| rst | output | 1 | System reset, active high |

## Verification
Two functions can land on the same clock edge. One is the filter accepting a push-button release. The other is a new supply drop, which reloads the hold count. The bench releases the button and then drives `supply_ok` low for exactly the edge at which the filtered level flips. The correct result is a single hold window measured from that shared edge. Reset must still be high one edge before DEB_CYC+2+HOLD_CYC and low at that edge, with no extra or missing cycle.

// File: rtl/rst_stretch_pkg.sv
package rst_stretch_pkg;
  typedef struct packed {
    logic power_on;
    logic brownout;
    logic button;
  } cause_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n + 1) : 1;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b1
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain = {STAGES{INIT}};

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain[0] <= d;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_debounce.sv
module rst_debounce #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk,
  input  logic lvl_in,
  output logic lvl_out
);
  localparam int unsigned CW = rst_stretch_pkg::cnt_width(DEB_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] run   = '0;
  logic          level = 1'b1;

  always_ff @(posedge clk) begin
    if (lvl_in != level) begin
      if (run == LAST) begin
        level <= lvl_in;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else begin
      run <= '0;
    end
  end

  assign lvl_out = level;
endmodule

// File: rtl/rst_hold.sv
module rst_hold #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic                    clk,
  input  rst_stretch_pkg::cause_t cause,
  output logic                    rst_hi,
  output logic                    rst_lo
);
  localparam int unsigned CW = rst_stretch_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

  logic [CW-1:0] left = FULL;
  logic          hi_q = 1'b1;
  logic          lo_q = 1'b0;
  logic          any_cause;
  logic          nxt;

  assign any_cause = |cause;

  always_comb begin
    nxt = any_cause || (left > CW'(1));
  end

  always_ff @(posedge clk) begin
    if (any_cause)          left <= FULL;
    else if (left != '0)    left <= left - 1'b1;
    hi_q <= nxt;
    lo_q <= ~nxt;
  end

  assign rst_hi = hi_q;
  assign rst_lo = lo_q;
endmodule

// File: rtl/rst_stretch_gen.sv
module rst_stretch_gen #(
  parameter int unsigned HOLD_CYC  = 20_000_000,
  parameter int unsigned DEB_CYC   = 100_000,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic mr_raw_n,
  output logic rst_n,
  output logic rst
);
  import rst_stretch_pkg::*;

  logic   pin_sync;
  logic   pin_clean;
  logic   por_q = 1'b1;
  cause_t cause;

  rst_sync #(.STAGES(SYNC_STG), .INIT(1'b1)) u_sync (
    .clk (clk),
    .d   (mr_raw_n),
    .q   (pin_sync)
  );

  rst_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk     (clk),
    .lvl_in  (pin_sync),
    .lvl_out (pin_clean)
  );

  always_ff @(posedge clk) por_q <= 1'b0;

  always_comb begin
    cause.power_on = por_q;
    cause.brownout = ~supply_ok;
    cause.button   = ~pin_clean;
  end

  rst_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .cause  (cause),
    .rst_hi (rst),
    .rst_lo (rst_n)
  );
endmodule

// File: rtl/rst_stretch_gen_chk.sv
module rst_stretch_gen_chk (
  input logic clk,
  input logic supply_ok,
  input logic mr_raw_n,
  input logic rst_n,
  input logic rst
);
  logic [2:0] age = '0;
  logic       warm;
  always_ff @(posedge clk) if (age != 3'd7) age <= age + 1'b1;
  assign warm = (age >= 3'd4);

  // R7
  a_r7_polarity: assert property (@(posedge clk) disable iff (age == 3'd0)
    rst_n == !rst);

  // R2
  a_r2_brownout_asserts: assert property (@(posedge clk) disable iff (!warm)
    !supply_ok |=> rst);

  // R5: release cannot follow an edge where the supply was low
  a_r5_release_needs_supply: assert property (@(posedge clk) disable iff (!warm)
    $fell(rst) |-> $past(supply_ok));

  // R3/R4: a new reset needs a low supply or a low pin three edges earlier
  a_r3_rise_has_cause: assert property (@(posedge clk) disable iff (!warm)
    $rose(rst) |-> (!$past(supply_ok) || !$past(mr_raw_n, 3)));
endmodule

bind rst_stretch_gen rst_stretch_gen_chk u_chk (.*);

// File: tb/tb_rst_stretch_gen.sv
module tb_rst_stretch_gen;
  localparam int CLK_P = 10;
  localparam int HOLD  = 8;
  localparam int DEB   = 3;

  logic clk = 1'b0;
  logic supply_ok = 1'b1;
  logic mr_raw_n = 1'b1;
  logic rst_n, rst;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_stretch_gen #(.HOLD_CYC(HOLD), .DEB_CYC(DEB)) dut (
    .clk(clk), .supply_ok(supply_ok), .mr_raw_n(mr_raw_n),
    .rst_n(rst_n), .rst(rst)
  );

  typedef struct packed {
    logic       sup;
    logic       pin;
    logic [7:0] edges;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b1, 8'd1,              1'b1, 4'd2},
    '{1'b1, 1'b1, 8'(HOLD-1),        1'b1, 4'd5},
    '{1'b1, 1'b1, 8'd1,              1'b0, 4'd5},
    '{1'b1, 1'b0, 8'(DEB+2),         1'b0, 4'd3},
    '{1'b1, 1'b0, 8'd1,              1'b1, 4'd3},
    '{1'b1, 1'b1, 8'd1,              1'b1, 4'd5},
    '{1'b1, 1'b1, 8'(DEB+HOLD),      1'b1, 4'd5},
    '{1'b1, 1'b1, 8'd1,              1'b0, 4'd5},
    '{1'b1, 1'b0, 8'(DEB-1),         1'b0, 4'd4},
    '{1'b1, 1'b1, 8'(DEB+HOLD+4),    1'b0, 4'd4}
  };

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (rst !== exp) begin
      n_bad++;
      $display("FAIL %s: rst=%b expected %b at %0t", req, rst, exp, $time);
    end
    n_chk++;
    if (rst_n !== ~exp) begin
      n_bad++;
      $display("FAIL R7 (%s): rst_n=%b expected %b", req, rst_n, ~exp);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: power-on hold
    wait_edges(HOLD);
    check(1'b1, "R1");
    wait_edges(1);
    check(1'b0, "R1");

    foreach (VECS[i]) begin
      supply_ok = VECS[i].sup;
      mr_raw_n  = VECS[i].pin;
      wait_edges(int'(VECS[i].edges));
      check(VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R6: a second brownout inside the hold reloads it
    supply_ok = 1'b0; wait_edges(1);
    supply_ok = 1'b1; wait_edges(4);
    check(1'b1, "R6");
    supply_ok = 1'b0; wait_edges(1);
    supply_ok = 1'b1; wait_edges(HOLD-1);
    check(1'b1, "R6");
    wait_edges(1);
    check(1'b0, "R6");

    // R5/R6: filtered button release and brownout on the same edge
    mr_raw_n = 1'b0; wait_edges(DEB+6);
    check(1'b1, "R3");
    mr_raw_n = 1'b1; wait_edges(DEB+1);
    supply_ok = 1'b0; wait_edges(1);
    supply_ok = 1'b1; wait_edges(HOLD-1);
    check(1'b1, "R5");
    wait_edges(1);
    check(1'b0, "R5");

    // R4: bouncing pin, each low burst shorter than the filter
    for (int k = 0; k < 4; k++) begin
      mr_raw_n = 1'b0; wait_edges(DEB-1);
      mr_raw_n = 1'b1; wait_edges(1);
    end
    wait_edges(DEB+3);
    check(1'b0, "R4");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule